// File: doc/BRIEF.md
# Opcode-Fetch Bank Controller

This block watches a CPU bus and picks the memory bank for every bus cycle, with no register in the I/O space. The CPU marks each opcode fetch with a fetch indicator. The block decodes three opcodes that the CPU treats as no-ops and uses them as commands. `$80` is a two-byte no-op, and its operand byte is loaded as a staged bank number. `$1A` promotes the staged bank to the live bank, which then applies to all later accesses. `$3A` arms a one-shot, so that the next write cycle, and only that one, goes to the staged bank.

Each bus cycle lasts one clock. The CPU's control and data inputs are stable before the rising edge that ends the cycle. The effective bank is a combinational function of the bank state and the current read/write level. All command state is updated at the edge that ends the cycle carrying the command. The effective bank is added above the CPU address to give an extended memory address.

Top module: `opfetch_bank_ctl`

## Requirements
- R1: A command byte (`$80`, `$1A`, `$3A`) is acted on only in a cycle where `fetch_i` is high. The same byte on the data bus in any other cycle leaves the live bank, the staged bank and the one-shot unchanged.
- R2: After a `$80` opcode cycle, the next cycle is the operand cycle. If `fetch_i` is low in that cycle, the low `BANK_W` bits of `data_i` become the staged bank.
- R3: A `$1A` opcode cycle copies the staged bank into the live bank, and `live_bank_o` shows it from the next cycle on. A `$80` alone never changes the live bank.
- R4: After a `$3A` opcode cycle, the first write cycle (`rw_i` = 0) drives the staged bank on `bank_o`.
- R5: The one-shot clears at the end of that write, so later writes use the live bank. Two `$3A` fetches before a write still redirect only one write.
- R6: Every read cycle (`rw_i` = 1) drives the live bank on `bank_o`, even while the one-shot is armed.
- R7: If `fetch_i` is high in the cycle after a `$80`, no operand is captured and the staged bank keeps its value. That cycle is decoded as an opcode in its own right.
- R8: While `rst` is high at a clock edge, the live bank and the staged bank are set to 0 and the one-shot is cleared.
- R9: `mem_addr_o` is `{bank_o, addr_i}`, with the bank in the upper `BANK_W` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, one bus cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | High during an opcode fetch cycle |
| rw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_i | input | ADDR_W | CPU address |
| data_i | input | 8 | CPU data bus, as read or written |
| bank_o | output | BANK_W | Effective bank for the current cycle |
| live_bank_o | output | BANK_W | Live bank currently in force |
| mem_addr_o | output | BANK_W+ADDR_W | Extended address `{bank_o, addr_i}` |

## Verification
The assertions assume that a cycle with `fetch_i` high is always a read. They also assume that data and control are steady at each rising edge. The stimulus drives inputs just after each edge and holds them for the whole cycle. It pairs a high `fetch_i` only with `rw_i` = 1, in both the directed sequences and the randomized phase. The randomized phase weights the data toward the three command bytes, so that cancelled operands, repeated arming and commits between arm and write all occur.

// File: rtl/obk_pkg.sv
package obk_pkg;

    // Command opcodes (no-ops on the CPU)
    localparam logic [7:0] OPC_STAGE  = 8'h80;   // two-byte, operand = bank
    localparam logic [7:0] OPC_COMMIT = 8'h1A;   // staged -> live
    localparam logic [7:0] OPC_ONCE   = 8'h3A;   // redirect next write

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STAGE  = 2'd1,
        CMD_COMMIT = 2'd2,
        CMD_ONCE   = 2'd3
    } cmd_e;

    typedef struct packed {
        cmd_e cmd;       // opcode decoded this cycle
        logic capture;   // this cycle is a valid operand cycle
    } dec_t;

    function automatic cmd_e classify(input logic fetch, input logic [7:0] byte_in);
        cmd_e c;
        c = CMD_NONE;
        if (fetch) begin
            case (byte_in)
                OPC_STAGE:  c = CMD_STAGE;
                OPC_COMMIT: c = CMD_COMMIT;
                OPC_ONCE:   c = CMD_ONCE;
                default:    c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/obk_decode.sv
module obk_decode
    import obk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fetch_i,
    input  logic [7:0] data_i,
    output dec_t       dec_o
);
    logic operand_due;

    // A $80 fetch makes the following cycle its operand cycle
    always_ff @(posedge clk) begin
        if (rst) operand_due <= 1'b0;
        else     operand_due <= (classify(fetch_i, data_i) == CMD_STAGE);
    end

    always_comb begin
        dec_o.cmd     = classify(fetch_i, data_i);
        // a fetch in the operand slot cancels the capture
        dec_o.capture = operand_due && !fetch_i;
    end
endmodule

// File: rtl/obk_bank_regs.sv
module obk_bank_regs
    import obk_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec_i,
    input  logic [7:0]        data_i,
    output logic [BANK_W-1:0] staged_o,
    output logic [BANK_W-1:0] live_o
);
    logic [BANK_W-1:0] staged_q, live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            live_q   <= '0;
        end else begin
            if (dec_i.capture)
                staged_q <= data_i[BANK_W-1:0];
            if (dec_i.cmd == CMD_COMMIT)
                live_q <= staged_q;
        end
    end

    assign staged_o = staged_q;
    assign live_o   = live_q;
endmodule

// File: rtl/obk_oneshot.sv
module obk_oneshot
    import obk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dec_t dec_i,
    input  logic rw_i,
    output logic armed_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (dec_i.cmd == CMD_ONCE)
            armed_q <= 1'b1;
        else if (armed_q && !rw_i)
            armed_q <= 1'b0;   // the redirected write has been used
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/opfetch_bank_ctl.sv
module opfetch_bank_ctl
    import obk_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fetch_i,
    input  logic                     rw_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [7:0]               data_i,
    output logic [BANK_W-1:0]        bank_o,
    output logic [BANK_W-1:0]        live_bank_o,
    output logic [BANK_W+ADDR_W-1:0] mem_addr_o
);
    localparam int EXT_W = BANK_W + ADDR_W;

    dec_t              dec;
    logic [BANK_W-1:0] staged, live;
    logic              armed;

    obk_decode u_dec (
        .clk(clk), .rst(rst), .fetch_i(fetch_i), .data_i(data_i), .dec_o(dec)
    );

    obk_bank_regs #(.BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst(rst), .dec_i(dec), .data_i(data_i),
        .staged_o(staged), .live_o(live)
    );

    obk_oneshot u_once (
        .clk(clk), .rst(rst), .dec_i(dec), .rw_i(rw_i), .armed_o(armed)
    );

    always_comb begin
        bank_o      = (armed && !rw_i) ? staged : live;
        live_bank_o = live;
    end

    assign mem_addr_o = EXT_W'({bank_o, addr_i});
endmodule

// File: rtl/opfetch_bank_ctl_chk.sv
module opfetch_bank_ctl_chk
    import obk_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     fetch_i,
    input logic                     rw_i,
    input logic [ADDR_W-1:0]        addr_i,
    input logic [7:0]               data_i,
    input logic [BANK_W-1:0]        bank_o,
    input logic [BANK_W-1:0]        live_bank_o,
    input logic [BANK_W+ADDR_W-1:0] mem_addr_o,
    input logic [BANK_W-1:0]        staged,
    input logic                     armed
);
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (live_bank_o == '0 && staged == '0 && !armed));

    p_no_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        !fetch_i && !$past(fetch_i && data_i == OPC_STAGE) |=> ($stable(staged) && $stable(live_bank_o)));

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        $past(fetch_i && data_i == OPC_STAGE) && !fetch_i |=> staged == $past(data_i[BANK_W-1:0]));

    p_commit_r3: assert property (@(posedge clk) disable iff (rst)
        fetch_i && data_i == OPC_COMMIT |=> live_bank_o == $past(staged));

    p_live_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(fetch_i && data_i == OPC_COMMIT) |=> $stable(live_bank_o));

    p_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        armed && !rw_i |-> bank_o == staged);

    p_single_r5: assert property (@(posedge clk) disable iff (rst)
        armed && !rw_i |=> !armed);

    p_read_live_r6: assert property (@(posedge clk) disable iff (rst)
        rw_i |-> bank_o == live_bank_o);

    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        $past(fetch_i && data_i == OPC_STAGE) && fetch_i |=> $stable(staged));

    p_concat_r9: assert property (@(posedge clk) disable iff (rst)
        mem_addr_o == {bank_o, addr_i});
endmodule

bind opfetch_bank_ctl opfetch_bank_ctl_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .fetch_i(fetch_i), .rw_i(rw_i), .addr_i(addr_i),
    .data_i(data_i), .bank_o(bank_o), .live_bank_o(live_bank_o),
    .mem_addr_o(mem_addr_o), .staged(staged), .armed(armed)
);

// File: tb/tb_opfetch_bank_ctl.sv
module tb_opfetch_bank_ctl;
    localparam int BW = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_i = 1'b0;
    logic          rw_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic [BW-1:0] bank_o, live_bank_o;
    logic [BW+AW-1:0] mem_addr_o;

    int errors = 0;
    int checks = 0;
    string tag = "R8";
    bit done = 0;

    // reference state
    int m_live = 0, m_staged = 0, m_armed = 0, m_due = 0;

    always #4 clk = ~clk;   // 125 MHz

    opfetch_bank_ctl #(.BANK_W(BW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .fetch_i(fetch_i), .rw_i(rw_i), .addr_i(addr_i),
        .data_i(data_i), .bank_o(bank_o), .live_bank_o(live_bank_o),
        .mem_addr_o(mem_addr_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model advances at each edge on the inputs of the ending cycle
    always @(posedge clk) begin
        if (rst) begin
            m_live = 0; m_staged = 0; m_armed = 0; m_due = 0;
        end else begin
            int nxt_due;
            nxt_due = (fetch_i && data_i == 8'h80) ? 1 : 0;
            if (m_due != 0 && !fetch_i) m_staged = data_i;
            if (fetch_i && data_i == 8'h1A) m_live = m_staged;
            if (fetch_i && data_i == 8'h3A) m_armed = 1;
            else if (m_armed != 0 && !rw_i) m_armed = 0;
            m_due = nxt_due;
        end
    end

    // compare mid-cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_bank;
            exp_bank = (m_armed != 0 && !rw_i) ? m_staged : m_live;
            check(rw_i ? "R6" : tag, int'(bank_o), exp_bank);
            check(tag, int'(live_bank_o), m_live);
            check("R9", int'(mem_addr_o), (exp_bank << AW) | int'(addr_i));
        end
    end

    task automatic cyc(bit f, bit rw, int a, int d);
        @(posedge clk); #1;
        fetch_i = f; rw_i = rw; addr_i = a[AW-1:0]; data_i = d[7:0];
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 16'h1000 + i, 8'hEA);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        check("R8", int'(live_bank_o), 0);
        check("R8", int'(bank_o), 0);

        // R1: command bytes outside fetch cycles
        tag = "R1";
        cyc(0, 1, 16'h2000, 8'h80); cyc(0, 1, 16'h2001, 8'h07);
        cyc(0, 1, 16'h2002, 8'h1A); cyc(0, 1, 16'h2003, 8'h3A);
        cyc(0, 0, 16'h2004, 8'h55); idle(1);
        #2 check("R1", int'(live_bank_o), 0);

        // R2/R3: stage 5, no switch yet, then commit
        tag = "R3";
        cyc(1, 1, 16'h0300, 8'h80); cyc(0, 1, 16'h0301, 8'h05);
        cyc(0, 0, 16'h4000, 8'h11); idle(1);
        #2 check("R3", int'(live_bank_o), 0);
        cyc(1, 1, 16'h0302, 8'h1A); idle(1);
        #2 check("R3", int'(live_bank_o), 5);

        // R4/R5/R6: stage 0x22, arm, read, write, write
        tag = "R4";
        cyc(1, 1, 16'h0303, 8'h80); cyc(0, 1, 16'h0304, 8'h22);
        cyc(1, 1, 16'h0305, 8'h3A);
        cyc(0, 1, 16'h5000, 8'h99);
        #2 check("R6", int'(bank_o), 5);
        cyc(0, 0, 16'h5001, 8'h44);
        #2 check("R4", int'(bank_o), 8'h22);
        tag = "R5";
        cyc(0, 0, 16'h5002, 8'h44);
        #2 check("R5", int'(bank_o), 5);
        cyc(1, 1, 16'h0306, 8'h3A); cyc(1, 1, 16'h0307, 8'h3A);
        cyc(0, 0, 16'h5003, 8'h01);
        #2 check("R5", int'(bank_o), 8'h22);
        cyc(0, 0, 16'h5004, 8'h02);
        #2 check("R5", int'(bank_o), 5);

        // R7: fetch in operand slot cancels capture, decoded as commit
        tag = "R7";
        cyc(1, 1, 16'h0308, 8'h80); cyc(1, 1, 16'h0309, 8'h1A); idle(1);
        #2 check("R7", int'(live_bank_o), 8'h22);
        cyc(1, 1, 16'h030A, 8'h80); cyc(1, 1, 16'h030B, 8'h80);
        cyc(0, 1, 16'h030C, 8'h09); cyc(1, 1, 16'h030D, 8'h1A); idle(1);
        #2 check("R7", int'(live_bank_o), 9);

        // randomized phase weighted toward command bytes
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            int sel, d;
            bit f, rw;
            sel = $urandom_range(0, 9);
            f   = ($urandom_range(0, 2) == 0);
            rw  = f ? 1'b1 : ($urandom_range(0, 2) != 0);
            case (sel)
                0, 1: d = 8'h80;
                2:    d = 8'h1A;
                3:    d = 8'h3A;
                default: d = $urandom_range(0, 255);
            endcase
            cyc(f, rw, $urandom_range(0, 65535), d);
        end

        // R8: reset mid-run
        tag = "R8";
        @(posedge clk); #1 rst = 1'b1; fetch_i = 0; rw_i = 1;
        @(posedge clk); #1 rst = 1'b0;
        #2 check("R8", int'(live_bank_o), 0);
        cyc(0, 0, 16'h0100, 8'h00);
        #2 check("R8", int'(bank_o), 0);
        idle(2);
        @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule